// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs the refill of one cache line after a read miss and lets the stalled processor continue as soon as the word it missed on comes back from memory. It takes a miss request carrying a word address and issues a single burst read that starts at that word. The beats that come back fill a line buffer in sub-block (XOR) order. The first beat is handed straight to the processor as an early-restart strobe with its data. The other words of the line keep landing in the background while the processor runs.

While the refill is in flight, the processor may ask for another word of the same line. The block answers from its own copy of the words that have already arrived, and it stalls the request if that word has not come in yet. Memory may leave idle cycles between beats, because the controller counts beats by valid strobes. The line counts as valid only once every word has been written. A one-cycle completion pulse follows the last beat.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: `miss_ready_o` is high only while no refill is in progress. A miss is taken in a cycle where `miss_valid_i` and `miss_ready_o` are both high. From the next cycle `miss_ready_o` stays low until the cycle after the completion pulse.
- R2: In the cycle after a miss is taken, `mem_req_o` is high for exactly one cycle. In that cycle `mem_addr_o` equals the missed word address, whose low log2(LINE_WORDS) bits are the critical word index.
- R3: The k-th accepted beat of a burst (k counting from 0) is written to line-buffer index (critical index XOR k). For example, a miss on word 2 writes words 2, 3, 0, 1.
- R4: `restart_o` is high in the same cycle as the first beat and in no other cycle. `restart_data_o` then equals `mem_rdata_i`.
- R5: Every beat, including those after the restart, raises `lb_we_o` in its own cycle with `lb_data_o` equal to `mem_rdata_i`.
- R6: Only a cycle with `mem_rvalid_i` high during the burst phase counts as a beat. A strobe while idle, or in the request cycle, writes nothing. Idle gaps between beats are allowed.
- R7: `done_o` is high for the one cycle after the cycle of the last beat. `line_valid_o` rises in that same cycle and stays high until the next miss is taken. It is low after reset and during a refill.
- R8: When `cpu_req_i` is high, `cpu_ack_o` goes high in the same cycle only if word `cpu_idx_i` was written in an earlier cycle of the current or last refill. `cpu_data_o` then carries that word. Otherwise the request is stalled (`cpu_ack_o` low), and this includes the case where the word arrives in that same cycle.
- R9: After reset, `miss_ready_o` is high and `mem_req_o`, `lb_we_o`, `restart_o`, `done_o` and `line_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Miss request present |
| miss_addr_i | input | ADDR_W | Missed word address |
| miss_ready_o | output | 1 | Controller idle, can take a miss |
| mem_req_o | output | 1 | Burst start pulse |
| mem_addr_o | output | ADDR_W | Burst start (critical) word address |
| mem_rvalid_i | input | 1 | Burst beat valid |
| mem_rdata_i | input | DATA_W | Burst beat data |
| lb_we_o | output | 1 | Line-buffer write enable |
| lb_idx_o | output | log2(LINE_WORDS) | Line-buffer word index |
| lb_data_o | output | DATA_W | Line-buffer write data |
| restart_o | output | 1 | Early-restart strobe |
| restart_data_o | output | DATA_W | Missed word for the processor |
| cpu_req_i | input | 1 | Same-line word request |
| cpu_idx_i | input | log2(LINE_WORDS) | Requested word index |
| cpu_ack_o | output | 1 | Request served this cycle |
| cpu_data_o | output | DATA_W | Served word |
| done_o | output | 1 | Refill complete pulse |
| line_valid_o | output | 1 | Whole line written |

## Verification
A beat counter that drifts shows up on the first beat that follows. `lb_idx_o` then points at the wrong word, and `done_o` arrives one beat early or late. A restart strobe that fires on a later beat, or a completion pulse shifted by a cycle, can be seen at the ports in the very cycle it happens. A corrupted arrival mask leaks out through `cpu_ack_o` at the next same-line request: either a stall that should not happen, or an acknowledge for a word that is still missing. An address register that is not loaded is visible in the request cycle on `mem_addr_o`.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REQ   = 2'd1,
      ST_BURST = 2'd2,
      ST_FIN   = 2'd3
   } cwf_state_e;
endpackage

// File: rtl/cwf_beat_order.sv
module cwf_beat_order #(
   parameter int LINE_WORDS = 4,
   parameter bit XOR_ORDER  = 1'b1,
   localparam int IDX_W     = $clog2(LINE_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             beat_i,
   input  logic [IDX_W-1:0] crit_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             first_o,
   output logic             last_o
);
   logic [IDX_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (start_i) cnt_q <= '0;
      else if (beat_i)  cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (XOR_ORDER) begin : g_subblock
         assign idx_o = crit_i ^ cnt_q;
      end else begin : g_wrap
         assign idx_o = crit_i + cnt_q;
      end
   endgenerate

   assign first_o = (cnt_q == '0);
   assign last_o  = (cnt_q == IDX_W'(LINE_WORDS - 1));

   AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_i && last_o && !start_i) |=> first_o); // R3
endmodule

// File: rtl/cwf_word_store.sv
module cwf_word_store #(
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32,
   localparam int IDX_W     = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_req_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic              rd_ack_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              full_o,
   output logic              empty_o
);
   logic [LINE_WORDS-1:0][DATA_W-1:0] data_q;
   logic [LINE_WORDS-1:0]             have_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         have_q <= '0;
      end else if (clear_i) begin
         have_q <= '0;
      end else begin
         for (int w = 0; w < LINE_WORDS; w++) begin
            if (we_i && widx_i == IDX_W'(w)) begin
               data_q[w] <= wdata_i;
               have_q[w] <= 1'b1;
            end
         end
      end
   end

   assign rd_ack_o  = rd_req_i && have_q[rd_idx_i];
   assign rd_data_o = data_q[rd_idx_i];
   assign full_o    = &have_q;
   assign empty_o   = ~|have_q;

   AST_NO_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> !have_q[widx_i]); // R3
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> empty_o); // R8
endmodule

// File: rtl/cwf_refill_fsm.sv
module cwf_refill_fsm
   import cwf_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid_i,
   input  logic [ADDR_W-1:0] miss_addr_i,
   input  logic              mem_rvalid_i,
   input  logic              last_beat_i,
   output logic              miss_ready_o,
   output logic              accept_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              beat_o,
   output logic              done_o,
   output logic              line_valid_o
);
   cwf_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              lvalid_q;

   assign miss_ready_o = (state_q == ST_IDLE);
   assign accept_o     = miss_ready_o && miss_valid_i;
   assign mem_req_o    = (state_q == ST_REQ);
   assign beat_o       = (state_q == ST_BURST) && mem_rvalid_i;
   assign done_o       = (state_q == ST_FIN);
   assign mem_addr_o   = addr_q;
   assign line_valid_o = lvalid_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (miss_valid_i) state_d = ST_REQ;
         ST_REQ:   state_d = ST_BURST;
         ST_BURST: if (beat_o && last_beat_i) state_d = ST_FIN;
         ST_FIN:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         lvalid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept_o) begin
            addr_q   <= miss_addr_i;
            lvalid_q <= 1'b0;
         end else if (beat_o && last_beat_i) begin
            lvalid_q <= 1'b1;
         end
      end
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !miss_ready_o); // R1
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && miss_ready_o); // R7
   AST_DONE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(beat_o)); // R7
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o); // R2
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter bit XOR_ORDER  = 1'b1,
   localparam int IDX_W     = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid_i,
   input  logic [ADDR_W-1:0] miss_addr_i,
   output logic              miss_ready_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              lb_we_o,
   output logic [IDX_W-1:0]  lb_idx_o,
   output logic [DATA_W-1:0] lb_data_o,
   output logic              restart_o,
   output logic [DATA_W-1:0] restart_data_o,
   input  logic              cpu_req_i,
   input  logic [IDX_W-1:0]  cpu_idx_i,
   output logic              cpu_ack_o,
   output logic [DATA_W-1:0] cpu_data_o,
   output logic              done_o,
   output logic              line_valid_o
);
   generate
      if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
         $error("LINE_WORDS must be a power of two of at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the word index width");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic             accept, beat, first, last;
   logic             full, empty;
   logic [IDX_W-1:0] widx;

   cwf_refill_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid_i (miss_valid_i),
      .miss_addr_i  (miss_addr_i),
      .mem_rvalid_i (mem_rvalid_i),
      .last_beat_i  (last),
      .miss_ready_o (miss_ready_o),
      .accept_o     (accept),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .beat_o       (beat),
      .done_o       (done_o),
      .line_valid_o (line_valid_o)
   );

   cwf_beat_order #(.LINE_WORDS(LINE_WORDS), .XOR_ORDER(XOR_ORDER)) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .beat_i  (beat),
      .crit_i  (mem_addr_o[IDX_W-1:0]),
      .idx_o   (widx),
      .first_o (first),
      .last_o  (last)
   );

   cwf_word_store #(.LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (accept),
      .we_i      (beat),
      .widx_i    (widx),
      .wdata_i   (mem_rdata_i),
      .rd_req_i  (cpu_req_i),
      .rd_idx_i  (cpu_idx_i),
      .rd_ack_o  (cpu_ack_o),
      .rd_data_o (cpu_data_o),
      .full_o    (full),
      .empty_o   (empty)
   );

   assign lb_we_o        = beat;
   assign lb_idx_o       = widx;
   assign lb_data_o      = mem_rdata_i;
   assign restart_o      = beat && first;
   assign restart_data_o = mem_rdata_i;

   AST_BURST_AT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid_i && miss_ready_o) |=> (mem_req_o && mem_addr_o == $past(miss_addr_i))); // R2
   AST_RESTART_ON_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (lb_we_o && lb_idx_o == mem_addr_o[IDX_W-1:0] && empty)); // R4
   AST_VALID_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid_o |-> full); // R7
   AST_ACK_NOT_ARRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_we_o && cpu_req_i && cpu_idx_i == lb_idx_o) |-> !cpu_ack_o); // R8
endmodule

// File: tb/cwf_refill_ctrl_tb_top.sv
module cwf_refill_ctrl_tb_top;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int WORDS  = 4;
   localparam int IDX_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              miss_valid;
   logic [ADDR_W-1:0] miss_addr;
   logic              miss_ready, mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_rvalid;
   logic [DATA_W-1:0] mem_rdata;
   logic              lb_we;
   logic [IDX_W-1:0]  lb_idx;
   logic [DATA_W-1:0] lb_data;
   logic              restart;
   logic [DATA_W-1:0] restart_data;
   logic              cpu_req;
   logic [IDX_W-1:0]  cpu_idx;
   logic              cpu_ack;
   logic [DATA_W-1:0] cpu_data;
   logic              done, line_valid;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   cwf_refill_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(WORDS)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .miss_ready_o(miss_ready),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr),
      .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
      .lb_we_o(lb_we), .lb_idx_o(lb_idx), .lb_data_o(lb_data),
      .restart_o(restart), .restart_data_o(restart_data),
      .cpu_req_i(cpu_req), .cpu_idx_i(cpu_idx), .cpu_ack_o(cpu_ack), .cpu_data_o(cpu_data),
      .done_o(done), .line_valid_o(line_valid)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic logic [DATA_W-1:0] word_val(input logic [ADDR_W-1:0] a, input int idx,
                                                   input int salt);
      return {a, 8'(idx), 8'(salt)};
   endfunction

   task automatic refill(input logic [ADDR_W-1:0] a, input int maxgap);
      bit arr[WORDS];
      int crit = int'(a[IDX_W-1:0]);
      int salt = int'($urandom % 256);
      for (int i = 0; i < WORDS; i++) arr[i] = 1'b0;
      @(negedge clk);
      miss_valid = 1'b1; miss_addr = a;
      #1 chk("R1", "ready before miss", miss_ready, 1);
      @(negedge clk);
      miss_valid = 1'b0;
      mem_rvalid = 1'($urandom % 2); mem_rdata = 32'hdead_beef;
      #1;
      chk("R2", "burst request", mem_req, 1);
      chk("R2", "burst address", mem_addr, a);
      chk("R1", "ready in request", miss_ready, 0);
      chk("R6", "no write in request cycle", lb_we, 0);
      chk("R7", "line not valid yet", line_valid, 0);
      for (int k = 0; k < WORDS; k++) begin
         int gap = int'($urandom % (maxgap + 1));
         int idx = crit ^ k;
         for (int g = 0; g < gap; g++) begin
            int ci = int'($urandom % WORDS);
            @(negedge clk);
            mem_rvalid = 1'b0; cpu_req = 1'b1; cpu_idx = IDX_W'(ci);
            #1;
            chk("R6", "no write in gap", lb_we, 0);
            chk("R2", "request single pulse", mem_req, 0);
            chk("R1", "ready low while busy", miss_ready, 0);
            chk("R8", "ack matches arrival", cpu_ack, arr[ci]);
            if (arr[ci]) chk("R8", "served data", cpu_data, word_val(a, ci, salt));
         end
         @(negedge clk);
         mem_rvalid = 1'b1; mem_rdata = word_val(a, idx, salt);
         cpu_req = 1'b1; cpu_idx = IDX_W'(idx);
         #1;
         chk("R5", "beat writes", lb_we, 1);
         chk("R3", "sub-block index", lb_idx, idx);
         chk("R5", "beat data", lb_data, word_val(a, idx, salt));
         chk("R4", "restart only on first beat", restart, (k == 0));
         if (k == 0) chk("R4", "restart data", restart_data, word_val(a, idx, salt));
         chk("R8", "stall on arriving word", cpu_ack, 0);
         chk("R7", "no done mid burst", done, 0);
         arr[idx] = 1'b1;
      end
      @(negedge clk);
      mem_rvalid = 1'b0; cpu_req = 1'b0;
      #1;
      chk("R7", "done after last beat", done, 1);
      chk("R7", "line valid with done", line_valid, 1);
      chk("R1", "ready low in done cycle", miss_ready, 0);
      chk("R6", "no write after burst", lb_we, 0);
      @(negedge clk);
      #1;
      chk("R7", "done single pulse", done, 0);
      chk("R1", "ready back", miss_ready, 1);
      chk("R7", "line valid held", line_valid, 1);
      begin
         int ci = int'($urandom % WORDS);
         cpu_req = 1'b1; cpu_idx = IDX_W'(ci);
         #1;
         chk("R8", "ack after fill", cpu_ack, 1);
         chk("R8", "data after fill", cpu_data, word_val(a, ci, salt));
      end
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0;
      mem_rvalid = 1'b0; mem_rdata = '0; cpu_req = 1'b0; cpu_idx = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R9", "reset ready", miss_ready, 1);
      chk("R9", "reset request", mem_req, 0);
      chk("R9", "reset write", lb_we, 0);
      chk("R9", "reset restart", restart, 0);
      chk("R9", "reset done", done, 0);
      chk("R9", "reset line valid", line_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mem_rvalid = 1'b1; cpu_req = 1'b1; cpu_idx = 2'd1;
      #1;
      chk("R6", "strobe ignored while idle", lb_we, 0);
      chk("R8", "no ack before any refill", cpu_ack, 0);
      mem_rvalid = 1'b0; cpu_req = 1'b0;
      for (int c = 0; c < WORDS; c++) refill(ADDR_W'(16'h1230 + c), 0);
      refill(16'h4442, 3);
      for (int n = 0; n < 40; n++) refill(ADDR_W'($urandom), 3);
      report();
      $finish;
   end
endmodule